// File: doc/BRIEF.md
# Dual Audio Baud-Rate Generator

The block holds two programmable rate dividers, A and B. Generator A serves the 44.1 kHz sample-rate family and generator B the 48 kHz family. All logic runs on one system clock. The four candidate source clocks arrive as one-cycle tick strobes: external inputs A, B and C and an internal clock. Each generator takes the ticks of the source its select field names. It passes them through a coarse prescaler of 2, 8, 32 or 128 and then through an 8-bit fine counter. Each time the full count completes, it emits a one-cycle enable pulse.

A small register port configures the block. Software writes two 10-bit rate words and a control word. The control word carries both source selects and the bit that decides which generator drives the shared clock-out enable. Both generators run independently and at the same time. The output mux only chooses which pulse train leaves on the shared line.

Each generator is a two-state machine. In GS_HALT its counters are held at zero and source ticks are ignored. In GS_RUN the ticks are counted. The transition GS_HALT to GS_RUN happens at a clock edge where the select field, as it stood before that edge, names a real source. The transition GS_RUN to GS_HALT happens at a clock edge where the select names no source. Reset enters GS_HALT.

Top module: `dual_baud_gen`

## Requirements
- R1: After reset, both rate words read 0x0FF (prescale code 0, N = 255) and the control word reads 0. Rate A is at address 0, rate B at address 1 and control at address 2.
- R2: A rate word stores bits [9:0] of the written data and reads back with bits [31:10] zero. In the control word only bit 31, bits [22:20] (select A) and bits [18:16] (select B) are stored. Every other control bit, and address 3, reads 0.
- R3: With rate bits [9:8] = c and bits [7:0] = N, a running generator pulses once every P×(N+1) ticks of its selected source, where P = 2, 8, 32 or 128 for c = 0, 1, 2 or 3.
- R4: Select code 0 picks source tick bit 0 (input A), 1 picks bit 1 (input B), 4 picks bit 2 (input C) and 2 picks bit 3 (internal clock). Codes 3, 5, 6 and 7 pick nothing: that generator then produces no pulses and enters GS_HALT.
- R5: A pulse lasts exactly one clock. It appears in the clock after the tick that completes the count, so two pulses are never adjacent.
- R6: Writing a rate word clears that generator's prescaler and fine counter, and a tick in the write cycle is not counted. A divide-by-2 setting with a tick on every cycle then pulses first two cycles after the write, and on every second cycle after that.
- R7: After reset, or after the select changes from an invalid code to a valid one, the tick in the first cycle spent in GS_HALT with a valid select is not counted.
- R8: The clock-out enable equals pulse B when control bit 31 is 1 and pulse A when it is 0, in the same cycle.
- R9: The two generators are independent. A write to one rate word does not alter the other generator's pulse train.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Source tick strobes: bit0 input A, bit1 input B, bit2 input C, bit3 internal |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 rate A, 1 rate B, 2 control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| pulse_a | output | 1 | Generator A divided enable |
| pulse_b | output | 1 | Generator B divided enable |
| clk_out | output | 1 | Shared clock-out enable, A or B per control bit 31 |

## Verification
A prescaler or fine counter holding a wrong value shifts the next pulse of that generator. The per-clock comparison against the behavioural model catches this at that pulse, at most P×(N+1) source ticks later. A missed restart on a rate write, or a wrong halt or resume, moves the first pulse after the write or select change by at least one cycle. The explicit first-pulse checks expose this within two or three clocks. A wrong source decode or a wrong output-select polarity changes the measured period, or makes clk_out follow the other generator, in the very next pulse.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int CODE_W   = 2;
    localparam int FINE_W   = 8;
    localparam int RATE_W   = CODE_W + FINE_W;
    localparam int SEL_W    = 3;
    localparam int NSRC     = 4;
    localparam int NGEN     = 2;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int PRE_W    = 2 * ((1 << CODE_W) - 1) + 1;

    localparam int OUTSEL_BIT = 31;
    localparam int SELA_LSB   = 20;
    localparam int SELB_LSB   = 16;

    localparam logic [ADDR_W-1:0] ADR_RATE_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_RATE_B = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_CTRL   = ADDR_W'(2);

    localparam logic [RATE_W-1:0] RATE_RST = RATE_W'(10'h0FF);

    typedef enum logic {
        GS_HALT = 1'b0,
        GS_RUN  = 1'b1
    } gen_state_e;

    function automatic int sel_lsb(input int g);
        return (g == 0) ? SELA_LSB : SELB_LSB;
    endfunction

    // last prescaler count for a given coarse code: 2<<(2*code) - 1
    function automatic logic [PRE_W-1:0] presc_last(input logic [CODE_W-1:0] code);
        logic [PRE_W:0] span;
        span = (PRE_W+1)'(1) << (2 * int'(code) + 1);
        span = span - (PRE_W+1)'(1);
        return span[PRE_W-1:0];
    endfunction

    function automatic logic src_valid(input logic [SEL_W-1:0] s);
        case (s)
            3'd0, 3'd1, 3'd2, 3'd4: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic src_pick(input logic [SEL_W-1:0] s,
                                      input logic [NSRC-1:0] t);
        case (s)
            3'd0:    return t[0];
            3'd1:    return t[1];
            3'd4:    return t[2];
            3'd2:    return t[3];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NGEN-1:0][RATE_W-1:0] rate,
    output logic [NGEN-1:0]            rate_wr,
    output logic [NGEN-1:0][SEL_W-1:0] sel,
    output logic                       out_b
);

    logic [NGEN-1:0][RATE_W-1:0] rate_q;
    logic [NGEN-1:0][SEL_W-1:0]  sel_q;
    logic                        outb_q;
    logic                        ctrl_wr;
    logic                        unused_wdata;

    assign unused_wdata = ^wr_data;
    assign ctrl_wr      = wr_en && (wr_addr == ADR_CTRL);

    for (genvar g = 0; g < NGEN; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADR = (g == 0) ? ADR_RATE_A : ADR_RATE_B;
        localparam int                MY_LSB = (g == 0) ? SELA_LSB : SELB_LSB;

        assign rate_wr[g] = wr_en && (wr_addr == MY_ADR);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rate_q[g] <= RATE_RST;
                sel_q[g]  <= '0;
            end else begin
                if (rate_wr[g])
                    rate_q[g] <= wr_data[RATE_W-1:0];
                if (ctrl_wr)
                    sel_q[g] <= wr_data[MY_LSB +: SEL_W];
            end
        end

        AST_RATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            rate_wr[g] |=> (rate_q[g] == $past(wr_data[RATE_W-1:0]))); // R2
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            outb_q <= 1'b0;
        else if (ctrl_wr)
            outb_q <= wr_data[OUTSEL_BIT];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_RATE_A: rd_data[RATE_W-1:0] = rate_q[0];
            ADR_RATE_B: rd_data[RATE_W-1:0] = rate_q[1];
            ADR_CTRL: begin
                rd_data[OUTSEL_BIT] = outb_q;
                for (int g = 0; g < NGEN; g++)
                    rd_data[sel_lsb(g) +: SEL_W] = sel_q[g];
            end
            default: rd_data = '0;
        endcase
    end

    assign rate  = rate_q;
    assign sel   = sel_q;
    assign out_b = outb_q;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (out_b == $past(wr_data[OUTSEL_BIT]))); // R2

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              rate_wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NSRC-1:0]   src_tick,
    output logic              pulse_o
);

    gen_state_e        state_q, state_d;
    logic [PRE_W-1:0]  pc_q, pc_d, pc_last;
    logic [FINE_W-1:0] fc_q, fc_d, fine_n;
    logic              pulse_q, pulse_d;
    logic              tick_sel, sel_ok;

    assign sel_ok   = src_valid(sel);
    assign tick_sel = src_pick(sel, src_tick);
    assign pc_last  = presc_last(rate[RATE_W-1:FINE_W]);
    assign fine_n   = rate[FINE_W-1:0];

    // state transitions: GS_HALT -> GS_RUN on a valid select,
    // GS_RUN -> GS_HALT on an invalid one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_HALT: if (sel_ok)  state_d = GS_RUN;
            GS_RUN:  if (!sel_ok) state_d = GS_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GS_HALT;
        else
            state_q <= state_d;
    end

    // counters and pulse
    always_comb begin
        pc_d    = pc_q;
        fc_d    = fc_q;
        pulse_d = 1'b0;
        if (rate_wr) begin
            pc_d = '0;
            fc_d = '0;
        end else begin
            unique case (state_q)
                GS_HALT: begin
                    pc_d = '0;
                    fc_d = '0;
                end
                GS_RUN: begin
                    if (tick_sel) begin
                        if (pc_q == pc_last) begin
                            pc_d = '0;
                            if (fc_q == fine_n) begin
                                fc_d    = '0;
                                pulse_d = 1'b1;
                            end else begin
                                fc_d = fc_q + 1'b1;
                            end
                        end else begin
                            pc_d = pc_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            fc_q    <= '0;
            pulse_q <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            fc_q    <= fc_d;
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R5
    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(tick_sel)); // R5
    AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |=> !pulse_q); // R4
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |=> !pulse_q); // R6

endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pulse_a,
    output logic              pulse_b,
    output logic              clk_out
);

    logic [NGEN-1:0][RATE_W-1:0] rate;
    logic [NGEN-1:0]             rate_wr;
    logic [NGEN-1:0][SEL_W-1:0]  sel;
    logic [NGEN-1:0]             pulse;
    logic                        out_b;

    baud_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rate    (rate),
        .rate_wr (rate_wr),
        .sel     (sel),
        .out_b   (out_b)
    );

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        baud_gen u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .rate     (rate[g]),
            .rate_wr  (rate_wr[g]),
            .sel      (sel[g]),
            .src_tick (src_tick),
            .pulse_o  (pulse[g])
        );
    end

    assign pulse_a = pulse[0];
    assign pulse_b = pulse[1];
    assign clk_out = out_b ? pulse[1] : pulse[0];

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_a && !pulse_b) |-> !clk_out); // R8

endmodule

// File: tb/sim_dual_baud_gen.sv
module sim_dual_baud_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  src_tick;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        pulse_a, pulse_b, clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [3:0] tick_mask = 4'hF;
    bit         tick_rand = 0;

    always #5 clk = ~clk;

    dual_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pulse_a(pulse_a), .pulse_b(pulse_b), .clk_out(clk_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_rate [2];
    int m_sel  [2];
    int m_pc   [2];
    int m_fc   [2];
    bit m_run  [2];
    bit m_exp  [2];
    bit m_outb;

    function automatic bit pick_tick(input int s, input logic [3:0] t);
        if (s == 0) return t[0];
        if (s == 1) return t[1];
        if (s == 4) return t[2];
        if (s == 2) return t[3];
        return 1'b0;
    endfunction

    function automatic bit sel_good(input int s);
        return (s == 0) || (s == 1) || (s == 2) || (s == 4);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                m_rate[g] = 255; m_sel[g] = 0; m_pc[g] = 0; m_fc[g] = 0;
                m_run[g] = 0; m_exp[g] = 0;
            end
            m_outb = 0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                int  presc, nval;
                bit  e;
                presc = 2 << (2 * (m_rate[g] / 256));
                nval  = m_rate[g] % 256;
                e = 0;
                if (wr_en && wr_addr == 2'(g)) begin
                    m_rate[g] = int'(wr_data[9:0]);
                    m_pc[g] = 0; m_fc[g] = 0;
                end else if (!m_run[g]) begin
                    m_pc[g] = 0; m_fc[g] = 0;
                end else if (pick_tick(m_sel[g], src_tick)) begin
                    m_pc[g]++;
                    if (m_pc[g] == presc) begin
                        m_pc[g] = 0;
                        m_fc[g]++;
                        if (m_fc[g] == nval + 1) begin
                            m_fc[g] = 0;
                            e = 1;
                        end
                    end
                end
                m_run[g] = sel_good(m_sel[g]);
                m_exp[g] = e;
            end
            if (wr_en && wr_addr == 2'd2) begin
                m_sel[0] = int'(wr_data[22:20]);
                m_sel[1] = int'(wr_data[18:16]);
                m_outb   = wr_data[31];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(pulse_a == m_exp[0], "R3 pulse_a vs model", pulse_a, m_exp[0]);
            check(pulse_b == m_exp[1], "R9 pulse_b vs model", pulse_b, m_exp[1]);
            check(clk_out == (m_outb ? m_exp[1] : m_exp[0]), "R8 clk_out vs model",
                  clk_out, m_outb ? m_exp[1] : m_exp[0]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        wr_en    = 1'b0;
        src_tick = tick_rand ? (4'($urandom) & tick_mask) : tick_mask;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    function automatic logic [31:0] ctrl_word(input bit ob, input int sa, input int sb);
        return {ob, 8'h00, 3'(sa), 1'b0, 3'(sb), 16'h0000};
    endfunction

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    function automatic bit gp(input int g);
        return (g == 0) ? pulse_a : pulse_b;
    endfunction

    task automatic measure(input int g, input int exp, input string tag);
        int cnt;
        int guard;
        bit prev;
        guard = 0;
        while (!gp(g) && guard < 4000) begin step(); guard++; end
        cnt = 0; prev = 1;
        do begin
            step(); cnt++;
            if (prev && gp(g))
                check(1'b0, "R5 adjacent pulses", 1, 0);
            prev = gp(g);
        end while (!gp(g) && cnt < 4000);
        check(cnt == exp, tag, cnt, exp);
    endtask

    task automatic first_pulse(input int g, input int exp, input string tag);
        int cnt;
        cnt = 0;
        do begin step(); cnt++; end while (!gp(g) && cnt < 4000);
        check(cnt == exp, tag, cnt, exp);
    endtask

    task automatic count_out(input int cycles, input int exp, input string tag);
        int c;
        c = 0;
        for (int i = 0; i < cycles; i++) begin step(); if (clk_out) c++; end
        check(c == exp, tag, c, exp);
    endtask

    task automatic count_b(input int cycles, input int exp, input string tag);
        int c;
        c = 0;
        for (int i = 0; i < cycles; i++) begin step(); if (pulse_b) c++; end
        check(c == exp, tag, c, exp);
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(150000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; src_tick = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        src_tick = tick_mask;

        // R1 reset values
        rd_check(2'd0, 32'h0FF, "R1 rate A reset");
        rd_check(2'd1, 32'h0FF, "R1 rate B reset");
        rd_check(2'd2, 32'h0,   "R1 control reset");

        // R2 write masks
        wr(2'd2, 32'hFFFF_FFFF);
        rd_check(2'd2, 32'h8077_0000, "R2 control mask");
        wr(2'd0, 32'hFFFF_FFFF);
        rd_check(2'd0, 32'h3FF, "R2 rate A width");
        wr(2'd3, 32'hFFFF_FFFF);
        rd_check(2'd3, 32'h0, "R2 unmapped address");

        // A on input A, B on input C
        wr(2'd2, ctrl_word(0, 0, 4));
        step();

        // R6 restart: divide-by-2
        wr(2'd0, 32'h000);
        first_pulse(0, 2, "R6 first pulse after rate write");
        measure(0, 2, "R6 divide-by-2 period");

        // R3 period for each prescale code and several N
        wr(2'd0, {22'd0, 2'd0, 8'd5});   measure(0, 12,  "R3 code0 N5");
        wr(2'd0, {22'd0, 2'd1, 8'd3});   measure(0, 32,  "R3 code1 N3");
        wr(2'd0, {22'd0, 2'd2, 8'd1});   measure(0, 64,  "R3 code2 N1");
        wr(2'd0, {22'd0, 2'd3, 8'd2});   measure(0, 384, "R3 code3 N2");
        wr(2'd0, {22'd0, 2'd2, 8'd7});   measure(0, 256, "R3 code2 N7");
        wr(2'd0, {22'd0, 2'd0, 8'd255}); measure(0, 512, "R3 code0 N255");

        // R4 source encoding: B div 8, only one source ticking each time
        wr(2'd1, {22'd0, 2'd0, 8'd3});
        tick_mask = 4'b0100; measure(1, 8, "R4 sel 4 picks input C");
        wr(2'd2, ctrl_word(0, 0, 2)); tick_mask = 4'b1000; measure(1, 8, "R4 sel 2 picks internal");
        wr(2'd2, ctrl_word(0, 0, 1)); tick_mask = 4'b0010; measure(1, 8, "R4 sel 1 picks input B");
        wr(2'd2, ctrl_word(0, 0, 0)); tick_mask = 4'b0001; measure(1, 8, "R4 sel 0 picks input A");
        tick_mask = 4'b0010;
        count_b(40, 0, "R4 sel 0 ignores input B");

        // R4 invalid selects
        tick_mask = 4'hF;
        wr(2'd2, ctrl_word(0, 0, 3)); count_b(60, 0, "R4 sel 3 halts");
        wr(2'd2, ctrl_word(0, 0, 7)); count_b(60, 0, "R4 sel 7 halts");

        // R7 resume from halt with divide-by-2
        wr(2'd1, 32'h000);
        wr(2'd2, ctrl_word(0, 0, 2));
        first_pulse(1, 3, "R7 resume drops first tick");

        // R8 output select and R9 independence
        wr(2'd0, 32'h000);
        wr(2'd1, {22'd0, 2'd0, 8'd3});
        wr(2'd2, ctrl_word(1, 0, 2));
        step();
        count_out(64, 8,  "R8 clk_out follows B");
        wr(2'd2, ctrl_word(0, 0, 2));
        count_out(64, 32, "R8 clk_out follows A");
        wr(2'd0, {22'd0, 2'd1, 8'd0});
        measure(1, 8, "R9 B unchanged by A write");

        // random ticks, model comparison each clock
        tick_rand = 1;
        wr(2'd0, {22'd0, 2'd0, 8'd2});
        wr(2'd1, {22'd0, 2'd1, 8'd1});
        wr(2'd2, ctrl_word(1, 4, 1));
        repeat (2000) step();
        wr(2'd2, ctrl_word(0, 2, 6));
        repeat (300) step();
        wr(2'd2, ctrl_word(1, 1, 0));
        repeat (2000) step();

        summary();
    end

endmodule